// File: doc/BRIEF.md
# Dual-Die Register and Buffer Steering

This block models the access-steering logic of a flash package that stacks two dies behind one host bus. Each die keeps its own copy of a block-address register and a buffer-select register and carries a strap that gives its die number. Comparators match the strap against the select bits, so that each die decides for itself whether to take part in an access. The flash array, the buffer contents and the command sequencing sit outside the block. Buffer read data enters on a per-die input, and the block produces per-die enables for buffer and core activity.

Register writes land in both dies. Register reads and data-buffer accesses follow the buffer-select bit. Boot-buffer accesses always go to the first die. Operation starts go to the die named by the core-select bit of the block-address register. A start that requests a double-rate program with an odd block number is flagged and not issued.

Top module: `dual_die_steer`

## Requirements
- R1: After reset both copies of both registers are 0000h, `rdata_o` is 0 and `drv_o` is 2'b01. Bit 0 of any per-die vector stands for die 1, whose strap is low, and bit 1 stands for die 2.
- R2: The block-address register is at F100h. Bit 15 is the core-select bit and bits 10:0 are the block number. Bits 14:11 ignore writes and read as zero, so a stored value equals the write data AND 87FFh. `core_blk_o` is {bit 15, bits 10:0}, a 12-bit number covering 4096 blocks.
- R3: The buffer-select register is at F101h. Only bit 15 is stored, and bits 14:0 read as zero, so a stored value equals the write data AND 8000h.
- R4: A register write updates the copies in both dies, whatever the buffer-select bit holds.
- R5: A read returns data on `rdata_o` one clock after `rd_i` is sampled. A register read returns the copy held by the die that the buffer-select bit names. A read of an unmapped address returns 0.
- R6: Boot-buffer accesses (words 0000h to 01FFh) assert `buf_en_o` = 2'b01 for a read or a write, whatever the buffer-select bit holds. A boot read returns the die-1 buffer data.
- R7: Data-buffer accesses (words 0200h to 09FFh) assert only the `buf_en_o` bit of the die named by the buffer-select bit. A data read returns that die's buffer data.
- R8: `drv_o` is always one-hot. It names the die that drives `rdata_o`: die 1 for a boot read, otherwise the die named by the buffer-select bit.
- R9: `core_en_o` is nonzero only while `start_i` is high. It then asserts the bit of the die named by the core-select bit.
- R10: The op codes are 0 load, 1 program, 2 erase, 3 double-rate program and 4 double-rate cache program. A start with op 3 or 4 while block bit 0 is 1 raises `fault_o` in the same cycle and leaves `core_en_o` at zero.
- R11: When a register write and a start or access fall in the same cycle, the steering uses the register values from before the write. The new values apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Host word address |
| wdata_i | input | 16 | Host write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| start_i | input | 1 | Operation start strobe |
| op_i | input | 3 | Operation code for the start |
| buf_rdata_i | input | 32 | Buffer read data, die 1 in [15:0], die 2 in [31:16] |
| rdata_o | output | 16 | Host read data, one cycle after the read |
| drv_o | output | 2 | Die driving the read-data bus, one-hot |
| buf_en_o | output | 2 | Per-die buffer access enable |
| core_en_o | output | 2 | Per-die core operation enable |
| core_blk_o | output | 12 | Block number across both dies |
| fault_o | output | 1 | Odd block with a double-rate program start |

## Verification
An operation start and a register write can share a cycle, because `start_i` is a separate strobe from the host write. The bench drives a write to F100h together with a double-rate start. The core enable and the fault flag in that cycle must follow the old block value, and the start in the following cycle must follow the new one. A start is also issued together with a data-buffer read. Both the per-die enables and the read data are compared against the bench's own model of the two register copies.

// File: rtl/dd_pkg.sv
package dd_pkg;
  localparam int OP_W = 3;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_BOOT,
    ACC_DATA,
    ACC_REG_BLK,
    ACC_REG_SEL
  } acc_e;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD     = 3'd0,
    OP_PROG     = 3'd1,
    OP_ERASE    = 3'd2,
    OP_DR_PROG  = 3'd3,
    OP_DR_CACHE = 3'd4
  } op_e;

  function automatic logic is_dual_rate(input logic [OP_W-1:0] op);
    return (op == OP_DR_PROG) || (op == OP_DR_CACHE);
  endfunction
endpackage

// File: rtl/dd_addr_dec.sv
module dd_addr_dec
  import dd_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned BOOT_BASE  = 32'h0000,
  parameter int unsigned BOOT_WORDS = 512,
  parameter int unsigned DATA_BASE  = 32'h0200,
  parameter int unsigned DATA_WORDS = 2048,
  parameter int unsigned REG_BLK    = 32'hF100,
  parameter int unsigned REG_SEL    = 32'hF101
) (
  input  logic [AW-1:0] addr_i,
  output acc_e          acc_o
);
  logic [31:0] addr_w;
  logic        in_boot, in_data;

  assign addr_w  = 32'(addr_i);
  // modular offset keeps a zero base free of constant compares
  assign in_boot = (addr_w - BOOT_BASE) < BOOT_WORDS;
  assign in_data = (addr_w - DATA_BASE) < DATA_WORDS;

  always_comb begin
    if (addr_w == REG_BLK)      acc_o = ACC_REG_BLK;
    else if (addr_w == REG_SEL) acc_o = ACC_REG_SEL;
    else if (in_boot)           acc_o = ACC_BOOT;
    else if (in_data)           acc_o = ACC_DATA;
    else                        acc_o = ACC_NONE;
  end
endmodule

// File: rtl/dd_rate_chk.sv
module dd_rate_chk
  import dd_pkg::*;
(
  input  logic            start_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            blk_lsb_i,
  output logic            fault_o
);
  assign fault_o = start_i && is_dual_rate(op_i) && blk_lsb_i;
endmodule

// File: rtl/dd_die.sv
module dd_die
  import dd_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned BLK_W = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strap_i,
  input  acc_e          acc_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          start_i,
  input  logic          hold_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] buf_rdata_i,
  output logic [DW-1:0] blk_o,
  output logic [DW-1:0] rdata_o,
  output logic          drv_o,
  output logic          buf_en_o,
  output logic          core_en_o
);
  localparam int unsigned RSV_W = DW - 1 - BLK_W;
  localparam logic [DW-1:0] BLK_KEEP = {1'b1, {RSV_W{1'b0}}, {BLK_W{1'b1}}};
  localparam logic [DW-1:0] SEL_KEEP = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] blk_q, sel_q, rdata_q, rd_val;
  logic          drv_q, drv_d, buf_hit, own_buf, own_core;

  assign own_buf  = sel_q[DW-1] == strap_i;
  assign own_core = blk_q[DW-1] == strap_i;

  always_comb begin
    unique case (acc_i)
      ACC_BOOT: buf_hit = !strap_i;
      ACC_DATA: buf_hit = own_buf;
      default:  buf_hit = 1'b0;
    endcase
  end

  assign drv_d = (rd_i && acc_i == ACC_BOOT) ? !strap_i : own_buf;

  always_comb begin
    unique case (acc_i)
      ACC_REG_BLK:        rd_val = blk_q;
      ACC_REG_SEL:        rd_val = sel_q;
      ACC_BOOT, ACC_DATA: rd_val = buf_rdata_i;
      default:            rd_val = '0;
    endcase
  end

  // register writes carry no strap check: both dies load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q <= '0;
      sel_q <= '0;
    end else if (wr_i) begin
      if (acc_i == ACC_REG_BLK) blk_q <= wdata_i & BLK_KEEP;
      if (acc_i == ACC_REG_SEL) sel_q <= wdata_i & SEL_KEEP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      drv_q   <= !strap_i;
    end else begin
      rdata_q <= (rd_i && drv_d) ? rd_val : '0;
      drv_q   <= drv_d;
    end
  end

  assign blk_o     = blk_q;
  assign rdata_o   = rdata_q;
  assign drv_o     = drv_q;
  assign buf_en_o  = (rd_i || wr_i) && buf_hit;
  assign core_en_o = start_i && !hold_i && own_core;
endmodule

// File: rtl/dual_die_steer.sv
module dual_die_steer
  import dd_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 16,
  parameter int unsigned BLK_W      = 11,
  parameter int unsigned BOOT_BASE  = 32'h0000,
  parameter int unsigned BOOT_WORDS = 512,
  parameter int unsigned DATA_BASE  = 32'h0200,
  parameter int unsigned DATA_WORDS = 2048,
  parameter int unsigned REG_BLK    = 32'hF100,
  parameter int unsigned REG_SEL    = 32'hF101
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic            start_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [2*DW-1:0] buf_rdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [1:0]      drv_o,
  output logic [1:0]      buf_en_o,
  output logic [1:0]      core_en_o,
  output logic [BLK_W:0]  core_blk_o,
  output logic            fault_o
);
  localparam int unsigned NDIE = 2;

  acc_e          acc;
  logic          fault;
  logic [DW-1:0] die_blk   [NDIE];
  logic [DW-1:0] die_rdata [NDIE];

  dd_addr_dec #(
    .AW(AW), .BOOT_BASE(BOOT_BASE), .BOOT_WORDS(BOOT_WORDS),
    .DATA_BASE(DATA_BASE), .DATA_WORDS(DATA_WORDS),
    .REG_BLK(REG_BLK), .REG_SEL(REG_SEL)
  ) u_dec (
    .addr_i(addr_i),
    .acc_o (acc)
  );

  // both copies match, die 1 supplies the block number
  dd_rate_chk u_rate (
    .start_i  (start_i),
    .op_i     (op_i),
    .blk_lsb_i(die_blk[0][0]),
    .fault_o  (fault)
  );

  for (genvar d = 0; d < NDIE; d++) begin : g_die
    dd_die #(.DW(DW), .BLK_W(BLK_W)) u_die (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .strap_i    (1'(d)),
      .acc_i      (acc),
      .wr_i       (wr_i),
      .rd_i       (rd_i),
      .start_i    (start_i),
      .hold_i     (fault),
      .wdata_i    (wdata_i),
      .buf_rdata_i(buf_rdata_i[d*DW +: DW]),
      .blk_o      (die_blk[d]),
      .rdata_o    (die_rdata[d]),
      .drv_o      (drv_o[d]),
      .buf_en_o   (buf_en_o[d]),
      .core_en_o  (core_en_o[d])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int d = 0; d < NDIE; d++) rdata_o |= die_rdata[d];
  end

  assign core_blk_o = {die_blk[0][DW-1], die_blk[0][BLK_W-1:0]};
  assign fault_o    = fault;
endmodule

// File: rtl/dual_die_steer_chk.sv
module dual_die_steer_chk #(
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 16,
  parameter int unsigned BLK_W      = 11,
  parameter int unsigned BOOT_BASE  = 32'h0000,
  parameter int unsigned BOOT_WORDS = 512,
  parameter int unsigned REG_BLK    = 32'hF100,
  parameter int unsigned REG_SEL    = 32'hF101
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [AW-1:0]  addr_i,
  input logic [DW-1:0]  wdata_i,
  input logic           wr_i,
  input logic           rd_i,
  input logic           start_i,
  input logic [DW-1:0]  rdata_o,
  input logic [1:0]     drv_o,
  input logic [1:0]     buf_en_o,
  input logic [1:0]     core_en_o,
  input logic [BLK_W:0] core_blk_o,
  input logic           fault_o
);
  logic boot_hit;
  assign boot_hit = (32'(addr_i) - BOOT_BASE) < BOOT_WORDS;

  a_r8_one_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(drv_o));

  a_r6_boot_die1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i || wr_i) && boot_hit |-> buf_en_o == 2'b01);

  a_r7_buf_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(buf_en_o));

  a_r9_core_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |-> core_en_o == 2'b00);

  a_r10_fault_blocks_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> core_en_o == 2'b00);

  a_r3_sel_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && 32'(addr_i) == REG_SEL |=> rdata_o[DW-2:0] == '0);

  a_r2_blk_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && 32'(addr_i) == REG_BLK |=>
      core_blk_o == {$past(wdata_i[DW-1]), $past(wdata_i[BLK_W-1:0])});
endmodule

bind dual_die_steer dual_die_steer_chk #(
  .AW(AW), .DW(DW), .BLK_W(BLK_W), .BOOT_BASE(BOOT_BASE),
  .BOOT_WORDS(BOOT_WORDS), .REG_BLK(REG_BLK), .REG_SEL(REG_SEL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .wr_i(wr_i), .rd_i(rd_i), .start_i(start_i), .rdata_o(rdata_o),
  .drv_o(drv_o), .buf_en_o(buf_en_o), .core_en_o(core_en_o),
  .core_blk_o(core_blk_o), .fault_o(fault_o)
);

// File: tb/dual_die_steer_bench.sv
module dual_die_steer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0, wdata_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0, start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] buf_rdata_i = '0;
  logic [15:0] rdata_o;
  logic [1:0]  drv_o, buf_en_o, core_en_o;
  logic [11:0] core_blk_o;
  logic        fault_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state: one copy of each register per die
  logic [15:0] m_blk [2];
  logic [15:0] m_sel [2];
  logic [15:0] m_rdata;
  logic [1:0]  m_drv;

  always #5 clk_i = !clk_i;

  dual_die_steer u_dual_die_steer (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int cls(input logic [15:0] a);
    if (a == 16'hF100) return 3;
    if (a == 16'hF101) return 4;
    if (a < 16'h0200) return 1;
    if (a < 16'h0A00) return 2;
    return 0;
  endfunction

  task automatic step(input string tag);
    int c, dbs, cs;
    logic [1:0] e_buf, e_core, n_drv;
    logic e_fault;
    logic [15:0] n_rdata;
    #1;
    c   = cls(addr_i);
    dbs = int'(m_sel[0][15]);
    e_buf = 2'b00;
    if (rd_i || wr_i) begin
      if (c == 1) e_buf = 2'b01;
      if (c == 2) e_buf = dbs ? 2'b10 : 2'b01;
    end
    chk({tag, (c == 1) ? " R6 buf_en" : " R7 buf_en"}, 32'(buf_en_o), 32'(e_buf));
    e_fault = start_i && (op_i == 3'd3 || op_i == 3'd4) && m_blk[0][0];
    cs = int'(m_blk[0][15]);
    e_core = (start_i && !e_fault) ? (cs ? 2'b10 : 2'b01) : 2'b00;
    chk({tag, " R10 fault"}, 32'(fault_o), 32'(e_fault));
    chk({tag, " R9 core_en"}, 32'(core_en_o), 32'(e_core));
    chk({tag, " R2 core_blk"}, 32'(core_blk_o), 32'({m_blk[0][15], m_blk[0][10:0]}));
    n_drv = (rd_i && c == 1) ? 2'b01 : (dbs ? 2'b10 : 2'b01);
    n_rdata = '0;
    if (rd_i) begin
      case (c)
        1: n_rdata = buf_rdata_i[15:0];
        2: n_rdata = dbs ? buf_rdata_i[31:16] : buf_rdata_i[15:0];
        3: n_rdata = m_blk[dbs];
        4: n_rdata = m_sel[dbs];
        default: n_rdata = '0;
      endcase
    end
    @(posedge clk_i);
    m_rdata = n_rdata;
    m_drv   = n_drv;
    if (wr_i && c == 3) for (int d = 0; d < 2; d++) m_blk[d] = wdata_i & 16'h87FF;
    if (wr_i && c == 4) for (int d = 0; d < 2; d++) m_sel[d] = wdata_i & 16'h8000;
    @(negedge clk_i);
    chk({tag, " R5 rdata"}, 32'(rdata_o), 32'(m_rdata));
    chk({tag, " R8 drv"}, 32'(drv_o), 32'(m_drv));
  endtask

  task automatic idle_in();
    wr_i = 0; rd_i = 0; start_i = 0; op_i = '0; wdata_i = '0; addr_i = 16'hFFFF;
  endtask

  task automatic acc(input logic [15:0] a, input bit rd, input bit wr,
                     input logic [15:0] wd, input string tag);
    idle_in();
    addr_i = a; rd_i = rd; wr_i = wr; wdata_i = wd;
    buf_rdata_i = {16'h2000 | {4'h0, a[11:0]}, 16'h1000 | {4'h0, a[11:0]}};
    step(tag);
    idle_in();
  endtask

  task automatic strt(input logic [2:0] op, input string tag);
    idle_in();
    start_i = 1; op_i = op;
    step(tag);
    idle_in();
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin m_blk[d] = '0; m_sel[d] = '0; end
    m_rdata = '0; m_drv = 2'b01;
    idle_in();
    repeat (3) @(negedge clk_i);
    chk("R1 reset rdata", 32'(rdata_o), 32'h0);
    chk("R1 reset drv", 32'(drv_o), 32'h1);
    chk("R1 reset core_blk", 32'(core_blk_o), 32'h0);
    rst_ni = 1;
    @(negedge clk_i);
    acc(16'hF100, 1, 0, 0, "R1 blk");
    acc(16'hF101, 1, 0, 0, "R1 sel");
    acc(16'h0000, 0, 0, 0, "R8 idle");

    acc(16'hF100, 0, 1, 16'hFFFF, "R2 wr");
    acc(16'hF100, 1, 0, 0, "R2 rd");
    acc(16'hF101, 0, 1, 16'hFFFF, "R3 wr");
    acc(16'hF101, 1, 0, 0, "R3 rd");
    acc(16'hF100, 1, 0, 0, "R4 die2 copy");
    acc(16'hF100, 0, 1, 16'h8005, "R4 wr dbs1");
    acc(16'hF101, 0, 1, 16'h0000, "R4 dbs0");
    acc(16'hF100, 1, 0, 0, "R4 die1 copy");
    acc(16'h5000, 1, 0, 0, "R5 unmapped");
    acc(16'hF101, 0, 1, 16'h8000, "R5 dbs1");
    acc(16'h0BAD, 1, 0, 0, "R5 unmapped dbs1");

    for (int t = 0; t < 2; t++)
      for (int w = 0; w < 2; w++)
        for (int d = 0; d < 2; d++) begin
          acc(16'hF101, 0, 1, d[0] ? 16'h8000 : 16'h0000, "R7 set dbs");
          acc(t[0] ? 16'h0345 : 16'h0012, !w[0], w[0], 16'h1234,
              t[0] ? "R7 data" : "R6 boot");
          acc(16'h0000, 0, 0, 0, "R8 after");
        end

    for (int b15 = 0; b15 < 2; b15++)
      for (int b0 = 0; b0 < 2; b0++) begin
        acc(16'hF100, 0, 1, {b15[0], 4'hF, 10'h2A5, b0[0]}, "R9 set blk");
        for (int op = 0; op < 5; op++) strt(op[2:0], "R10 start");
      end

    acc(16'hF100, 0, 1, 16'h0004, "R11 base");
    idle_in();
    addr_i = 16'hF100; wr_i = 1; wdata_i = 16'h8003; start_i = 1; op_i = 3'd3;
    step("R11 wr+start");
    idle_in();
    strt(3'd3, "R11 next");
    strt(3'd1, "R11 next core");
    idle_in();
    addr_i = 16'h0400; rd_i = 1; start_i = 1; op_i = 3'd2;
    buf_rdata_i = 32'hBEEF_CAFE;
    step("R11 rd+start");
    idle_in();
    acc(16'hF101, 0, 1, 16'h8000, "R11 dbs1");
    idle_in();
    addr_i = 16'h0400; rd_i = 1; start_i = 1; op_i = 3'd4;
    step("R11 rd+start dbs1");
    idle_in();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule